// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block is the processor-side reservation keeper for atomic read-modify-write sequences. It sits between the core's load/store unit and the memory port. Every access passes through it. When a load-linked access completes, the block remembers which 16-byte granule was read and raises a lock flag. When a later store-conditional arrives, the block checks it against that reservation. A store-conditional that cannot succeed is answered at once with a failure code and never reaches memory. A store-conditional that passes the check is forwarded, and the memory's verdict is returned to the core.

A store-conditional aimed at uncacheable space bypasses the check. It always goes to memory, and the core receives a dedicated result code telling it not to write its destination register. The block also counts consecutive local failures and pulses a warning each time the count reaches a multiple of the warning period, which helps spot software caught in a retry loop. Any store-conditional that completes with a nonzero code clears the count.

Both sides of the request path use valid/ready. A request is accepted on a cycle where `core_req_valid` and `core_req_ready` are both high. The core must hold the request stable until it is accepted. Only one forwarded access may be outstanding, so `core_req_ready` stays low from the acceptance of a forwarded request until its memory response arrives. A forwarded request is accepted only when `mem_req_ready` is high, while a locally failed store-conditional is accepted regardless of `mem_req_ready`. Responses are strobes with no back-pressure, and the core must take `core_rsp_*` on the cycle `core_rsp_valid` is high.

Top module: `llsc_monitor`

## Requirements
- R1: Command encoding on `core_req_cmd` is 0 load, 1 store, 2 load-linked, 3 store-conditional. When a load-linked's memory response arrives, the lock flag is set and the lock address becomes the request address with its low 4 bits cleared. A cacheable store-conditional is then forwarded to memory if any address in the same 16-byte granule is used.
- R2: A cacheable store-conditional is a local failure when the lock flag is clear or its granule differs from the lock address. A local failure issues no memory request (`mem_req_valid` stays 0). It is accepted and answered in the same cycle with `core_rsp_valid`=1, `core_rsp_sc_code`=0 and `core_rsp_sc_wb`=1.
- R3: A local failure clears the lock flag, so a following store-conditional to the previously reserved granule also fails locally.
- R4: A store-conditional with `core_req_uncached`=1 is always forwarded, whatever the lock state. Its response carries code 2 and `core_rsp_sc_wb`=0, and the memory's own code is ignored.
- R5: A forwarded cacheable store-conditional returns the memory's code unchanged (0 fail, 1 success) with `core_rsp_sc_wb`=1.
- R6: `fail_count` increases by one in the cycle after each local failure. `livelock_warn` is high for exactly one cycle, the cycle in which `fail_count` becomes a nonzero multiple of WARN_PERIOD (default 100000).
- R7: A store-conditional response with a nonzero code (1 or 2) sets `fail_count` to 0 in the next cycle. A response with code 0 from memory leaves it unchanged.
- R8: Loads and stores are forwarded with address, data and command unchanged. A load returns `mem_rsp_rdata` on `core_rsp_rdata` with `core_rsp_sc_code`=0 and `core_rsp_sc_wb`=0. Neither loads nor stores change the lock flag or the lock address.
- R9: After reset the lock flag is clear, `fail_count` is 0, `livelock_warn` is 0, and neither `core_rsp_valid` nor `mem_req_valid` is high until a request is presented.
- R10: A forwarded request is accepted only while `mem_req_ready` is high, and at most one forwarded access is outstanding at a time. A local failure is accepted even while `mem_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core request present |
| core_req_ready | output | 1 | Core request accepted this cycle |
| core_req_cmd | input | 2 | 0 load, 1 store, 2 load-linked, 3 store-conditional |
| core_req_addr | input | ADDR_W | Physical address |
| core_req_wdata | input | DATA_W | Store data |
| core_req_uncached | input | 1 | Target is uncacheable |
| core_rsp_valid | output | 1 | Response strobe to core |
| core_rsp_rdata | output | DATA_W | Load data |
| core_rsp_sc_code | output | 2 | Store-conditional result: 0 fail, 1 pass, 2 uncached |
| core_rsp_sc_wb | output | 1 | Core should write the result into its destination |
| mem_req_valid | output | 1 | Forwarded request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_cmd | output | 2 | Forwarded command |
| mem_req_addr | output | ADDR_W | Forwarded address |
| mem_req_wdata | output | DATA_W | Forwarded store data |
| mem_req_uncached | output | 1 | Forwarded uncacheable attribute |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_rdata | input | DATA_W | Memory read data |
| mem_rsp_sc_code | input | 2 | Memory store-conditional verdict |
| livelock_warn | output | 1 | One-cycle pulse on every WARN_PERIOD-th consecutive local failure |
| fail_count | output | CNT_W | Consecutive local failure count |

## Verification
The bench targets the granule boundary. An access at offset 0xC of the reserved granule must be forwarded, while offset 0x10 must fail. A design that compared full addresses, or masked the wrong number of bits, would fail or forward the wrong one. The bench also checks that a failed store-conditional disarms the reservation, since a design that left the flag set would forward the retry. Uncacheable store-conditionals are sent while no reservation is held and with the memory answering 0, which exposes any design that filtered them or passed the memory code through. The bench runs the failure counter up to exactly 100000 to catch an off-by-one warning or a pulse longer than one cycle. It also checks that a memory-side failure does not clear the count, and it holds `mem_req_ready` low to show that local failures still drain while forwarded requests wait.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } op_e;

  localparam logic [1:0] RC_FAIL     = 2'd0;
  localparam logic [1:0] RC_PASS     = 2'd1;
  localparam logic [1:0] RC_UNCACHED = 2'd2;
endpackage

// File: rtl/llsc_lock_reg.sv
module llsc_lock_reg #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              clr_en,
  output logic              flag_o,
  output logic [ADDR_W-1:0] gran_o
);
  localparam logic [ADDR_W-1:0] LOW_ONES  = ADDR_W'((64'd1 << GRAN_BITS) - 64'd1);
  localparam logic [ADDR_W-1:0] GRAN_MASK = ~LOW_ONES;

  logic              flag_q;
  logic [ADDR_W-1:0] gran_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      gran_q <= '0;
    end else if (set_en) begin
      flag_q <= 1'b1;
      gran_q <= set_addr & GRAN_MASK;
    end else if (clr_en) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign gran_o = gran_q;
endmodule

// File: rtl/llsc_precheck.sv
module llsc_precheck
  import llsc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 4
) (
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              uncached_i,
  input  logic              lock_flag_i,
  input  logic [ADDR_W-1:0] lock_gran_i,
  output logic              fail_o
);
  localparam logic [ADDR_W-1:0] LOW_ONES  = ADDR_W'((64'd1 << GRAN_BITS) - 64'd1);
  localparam logic [ADDR_W-1:0] GRAN_MASK = ~LOW_ONES;

  logic is_cond;
  logic same_gran;

  always_comb begin
    is_cond   = (op_e'(op_i) == OP_COND);
    same_gran = ((addr_i & GRAN_MASK) == lock_gran_i);
    fail_o    = is_cond && !uncached_i && (!lock_flag_i || !same_gran);
  end
endmodule

// File: rtl/llsc_fail_ctr.sv
module llsc_fail_ctr #(
  parameter int WARN_PERIOD = 100000,
  parameter int CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             warn_o
);
  localparam int PHASE_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(WARN_PERIOD - 1);

  logic [CNT_W-1:0]   count_q;
  logic [PHASE_W-1:0] phase_q;
  logic               warn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      phase_q <= '0;
      warn_q  <= 1'b0;
    end else if (clr_i) begin
      count_q <= '0;
      phase_q <= '0;
      warn_q  <= 1'b0;
    end else if (inc_i) begin
      count_q <= count_q + 1'b1;
      if (phase_q == PHASE_LAST) begin
        phase_q <= '0;
        warn_q  <= 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
        warn_q  <= 1'b0;
      end
    end else begin
      warn_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign warn_o  = warn_q;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req_valid,
  output logic              core_req_ready,
  input  logic [1:0]        core_req_cmd,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [DATA_W-1:0] core_req_wdata,
  input  logic              core_req_uncached,
  output logic              core_rsp_valid,
  output logic [DATA_W-1:0] core_rsp_rdata,
  output logic [1:0]        core_rsp_sc_code,
  output logic              core_rsp_sc_wb,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [1:0]        mem_req_cmd,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  output logic              mem_req_uncached,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  input  logic [1:0]        mem_rsp_sc_code,
  output logic              livelock_warn,
  output logic [CNT_W-1:0]  fail_count
);
  logic              busy_q;
  op_e               pend_op_q;
  logic              pend_unc_q;
  logic [ADDR_W-1:0] pend_addr_q;

  logic              lock_flag;
  logic [ADDR_W-1:0] lock_gran;
  logic              local_fail;
  logic              idle;
  logic              local_fire;
  logic              fwd_fire;
  logic              rsp_fire;
  logic              link_done;
  logic              ctr_clr;

  llsc_precheck #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_precheck (
    .op_i        (core_req_cmd),
    .addr_i      (core_req_addr),
    .uncached_i  (core_req_uncached),
    .lock_flag_i (lock_flag),
    .lock_gran_i (lock_gran),
    .fail_o      (local_fail)
  );

  // Handshake: forwarded requests wait for memory; local failures do not.
  assign idle           = !busy_q;
  assign local_fire     = core_req_valid && idle && local_fail;
  assign mem_req_valid  = core_req_valid && idle && !local_fail;
  assign core_req_ready = idle && (local_fail || mem_req_ready);
  assign fwd_fire       = mem_req_valid && mem_req_ready;
  assign rsp_fire       = busy_q && mem_rsp_valid;

  assign mem_req_cmd      = core_req_cmd;
  assign mem_req_addr     = core_req_addr;
  assign mem_req_wdata    = core_req_wdata;
  assign mem_req_uncached = core_req_uncached;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      pend_op_q   <= OP_LOAD;
      pend_unc_q  <= 1'b0;
      pend_addr_q <= '0;
    end else if (fwd_fire) begin
      busy_q      <= 1'b1;
      pend_op_q   <= op_e'(core_req_cmd);
      pend_unc_q  <= core_req_uncached;
      pend_addr_q <= core_req_addr;
    end else if (rsp_fire) begin
      busy_q <= 1'b0;
    end
  end

  assign link_done = rsp_fire && (pend_op_q == OP_LINK);

  llsc_lock_reg #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (link_done),
    .set_addr (pend_addr_q),
    .clr_en   (local_fire),
    .flag_o   (lock_flag),
    .gran_o   (lock_gran)
  );

  // Response path: local failure answers in the accept cycle.
  always_comb begin
    core_rsp_valid   = 1'b0;
    core_rsp_rdata   = '0;
    core_rsp_sc_code = RC_FAIL;
    core_rsp_sc_wb   = 1'b0;
    if (local_fire) begin
      core_rsp_valid   = 1'b1;
      core_rsp_sc_code = RC_FAIL;
      core_rsp_sc_wb   = 1'b1;
    end else if (rsp_fire) begin
      core_rsp_valid = 1'b1;
      unique case (pend_op_q)
        OP_LOAD, OP_LINK: core_rsp_rdata = mem_rsp_rdata;
        OP_COND: begin
          if (pend_unc_q) begin
            core_rsp_sc_code = RC_UNCACHED;
            core_rsp_sc_wb   = 1'b0;
          end else begin
            core_rsp_sc_code = mem_rsp_sc_code;
            core_rsp_sc_wb   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign ctr_clr = rsp_fire && (pend_op_q == OP_COND) && (core_rsp_sc_code != RC_FAIL);

  llsc_fail_ctr #(.WARN_PERIOD(WARN_PERIOD), .CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (local_fire),
    .clr_i   (ctr_clr),
    .count_o (fail_count),
    .warn_o  (livelock_warn)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req_valid,
  input logic              core_req_ready,
  input logic [1:0]        core_req_cmd,
  input logic              core_req_uncached,
  input logic              core_rsp_valid,
  input logic [1:0]        core_rsp_sc_code,
  input logic              core_rsp_sc_wb,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              livelock_warn,
  input logic [CNT_W-1:0]  fail_count
);
  // R2
  local_fail_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_valid && core_req_ready && !mem_req_valid)
      |-> (core_rsp_valid && core_rsp_sc_code == 2'd0 && core_rsp_sc_wb
           && core_req_cmd == 2'd3 && !core_req_uncached));

  // R4
  uncached_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rsp_valid && core_rsp_sc_code == 2'd2) |-> !core_rsp_sc_wb);

  // R6
  warn_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    livelock_warn |=> !livelock_warn);

  // R6
  fail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_valid && core_req_ready && !mem_req_valid)
      |=> (fail_count == $past(fail_count) + 1'b1));

  // R7
  pass_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rsp_valid && core_rsp_sc_code != 2'd0) |=> (fail_count == '0));

  // R10
  mem_ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |-> !core_req_ready);
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .core_req_valid    (core_req_valid),
  .core_req_ready    (core_req_ready),
  .core_req_cmd      (core_req_cmd),
  .core_req_uncached (core_req_uncached),
  .core_rsp_valid    (core_rsp_valid),
  .core_rsp_sc_code  (core_rsp_sc_code),
  .core_rsp_sc_wb    (core_rsp_sc_wb),
  .mem_req_valid     (mem_req_valid),
  .mem_req_ready     (mem_req_ready),
  .livelock_warn     (livelock_warn),
  .fail_count        (fail_count)
);

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 32;
  localparam int PERIOD = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_req_valid = 1'b0;
  logic          core_req_ready;
  logic [1:0]    core_req_cmd = 2'd0;
  logic [AW-1:0] core_req_addr = '0;
  logic [DW-1:0] core_req_wdata = '0;
  logic          core_req_uncached = 1'b0;
  logic          core_rsp_valid;
  logic [DW-1:0] core_rsp_rdata;
  logic [1:0]    core_rsp_sc_code;
  logic          core_rsp_sc_wb;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b1;
  logic [1:0]    mem_req_cmd;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_req_uncached;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_rdata = '0;
  logic [1:0]    mem_rsp_sc_code = 2'd0;
  logic          livelock_warn;
  logic [CW-1:0] fail_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .DATA_W(DW), .GRAN_BITS(4), .WARN_PERIOD(PERIOD), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
    .core_req_cmd(core_req_cmd), .core_req_addr(core_req_addr),
    .core_req_wdata(core_req_wdata), .core_req_uncached(core_req_uncached),
    .core_rsp_valid(core_rsp_valid), .core_rsp_rdata(core_rsp_rdata),
    .core_rsp_sc_code(core_rsp_sc_code), .core_rsp_sc_wb(core_rsp_sc_wb),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_cmd(mem_req_cmd), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_uncached(mem_req_uncached),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .mem_rsp_sc_code(mem_rsp_sc_code),
    .livelock_warn(livelock_warn), .fail_count(fail_count)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Forwarded access: request, then memory answers one cycle later.
  task automatic fwd(input logic [1:0] cmd, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                     input logic unc, input logic [1:0] mcode, input logic [DW-1:0] mrd,
                     input logic [1:0] ecode, input logic ewb, input logic [DW-1:0] erd,
                     input string tag);
    @(negedge clk);
    core_req_valid = 1'b1; core_req_cmd = cmd; core_req_addr = addr;
    core_req_wdata = wd; core_req_uncached = unc;
    #1;
    chk(mem_req_valid == 1'b1, {tag, " fwd valid"}, mem_req_valid, 1);
    chk(mem_req_addr == addr && mem_req_cmd == cmd && mem_req_wdata == wd && mem_req_uncached == unc,
        {tag, " fwd fields"}, mem_req_addr, addr);
    chk(core_rsp_valid == 1'b0, {tag, " no early rsp"}, core_rsp_valid, 0);
    @(negedge clk);
    core_req_valid = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_sc_code = mcode; mem_rsp_rdata = mrd;
    #1;
    chk(core_rsp_valid == 1'b1, {tag, " rsp valid"}, core_rsp_valid, 1);
    chk(core_rsp_sc_code == ecode, {tag, " rsp code"}, core_rsp_sc_code, ecode);
    chk(core_rsp_sc_wb == ewb, {tag, " rsp wb"}, core_rsp_sc_wb, ewb);
    chk(core_rsp_rdata == erd, {tag, " rsp data"}, core_rsp_rdata, erd);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  // Store-conditional expected to fail locally.
  task automatic sc_local(input logic [AW-1:0] addr, input string tag);
    @(negedge clk);
    core_req_valid = 1'b1; core_req_cmd = 2'd3; core_req_addr = addr;
    core_req_uncached = 1'b0;
    #1;
    chk(mem_req_valid == 1'b0, {tag, " no mem req"}, mem_req_valid, 0);
    chk(core_req_ready && core_rsp_valid, {tag, " same-cycle rsp"}, core_rsp_valid, 1);
    chk(core_rsp_sc_code == 2'd0 && core_rsp_sc_wb, {tag, " code0 wb1"}, core_rsp_sc_code, 0);
    @(negedge clk);
    core_req_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(fail_count == 0, "R9 count", fail_count, 0);
    chk(livelock_warn == 0, "R9 warn", livelock_warn, 0);
    chk(!core_rsp_valid && !mem_req_valid, "R9 idle valids", core_rsp_valid, 0);
    sc_local(32'h1000, "R9 flag clear");
    chk(fail_count == 1, "R6 count after fail", fail_count, 1);
  endtask

  task automatic t_granule();
    fwd(2'd2, 32'h1004, 0, 0, 0, 32'hCAFE0001, 0, 0, 32'hCAFE0001, "R1 link");
    fwd(2'd3, 32'h100C, 32'h55, 0, 2'd1, 0, 2'd1, 1, 0, "R1 same granule");
    chk(fail_count == 0, "R7 pass clears", fail_count, 0);
    fwd(2'd2, 32'h1004, 0, 0, 0, 0, 0, 0, 0, "R1 relink");
    sc_local(32'h1010, "R2 next granule");
    sc_local(32'h1004, "R3 flag cleared");
    chk(fail_count == 2, "R6 count two", fail_count, 2);
  endtask

  task automatic t_plain();
    fwd(2'd2, 32'h2000, 0, 0, 0, 0, 0, 0, 0, "R8 link");
    fwd(2'd1, 32'h3000, 32'hABCD, 0, 0, 0, 0, 0, 0, "R8 store");
    fwd(2'd0, 32'h4000, 0, 0, 2'd1, 32'h12345678, 0, 0, 32'h12345678, "R8 load");
    chk(fail_count == 2, "R8 count untouched", fail_count, 2);
    fwd(2'd3, 32'h2008, 32'h7, 0, 2'd1, 0, 2'd1, 1, 0, "R8 lock intact");
    chk(fail_count == 0, "R7 cleared", fail_count, 0);
  endtask

  task automatic t_mem_fail();
    sc_local(32'h9000, "R6 prep fail");
    fwd(2'd2, 32'h5000, 0, 0, 0, 0, 0, 0, 0, "R5 link");
    fwd(2'd3, 32'h5004, 32'h1, 0, 2'd0, 0, 2'd0, 1, 0, "R5 memory verdict");
    chk(fail_count == 1, "R7 mem zero keeps count", fail_count, 1);
  endtask

  task automatic t_uncached();
    sc_local(32'h6000, "R6 prep");
    chk(fail_count == 2, "R6 count", fail_count, 2);
    fwd(2'd3, 32'h7000, 32'h9, 1, 2'd0, 0, 2'd2, 0, 0, "R4 uncached");
    chk(fail_count == 0, "R7 uncached clears", fail_count, 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    mem_req_ready = 1'b0;
    core_req_valid = 1'b1; core_req_cmd = 2'd2; core_req_addr = 32'h8000;
    core_req_uncached = 1'b0;
    #1;
    chk(mem_req_valid && !core_req_ready, "R10 held by memory", core_req_ready, 0);
    @(negedge clk);
    chk(!core_req_ready, "R10 still held", core_req_ready, 0);
    core_req_cmd = 2'd3; core_req_addr = 32'h8800;
    #1;
    chk(core_req_ready && core_rsp_valid && !mem_req_valid, "R10 local fail drains", core_req_ready, 1);
    @(negedge clk);
    chk(fail_count == 1, "R10 fail counted", fail_count, 1);
    core_req_cmd = 2'd2; core_req_addr = 32'h8000;
    mem_req_ready = 1'b1;
    #1;
    chk(core_req_ready, "R10 released", core_req_ready, 1);
    @(negedge clk);
    core_req_cmd = 2'd0;
    #1;
    chk(!core_req_ready, "R10 one outstanding", core_req_ready, 0);
    core_req_valid = 1'b0;
    mem_rsp_valid = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    fwd(2'd3, 32'h800F, 0, 0, 2'd1, 0, 2'd1, 1, 0, "R1 link after stall");
  endtask

  task automatic t_livelock();
    int pulses = 0;
    int bad = 0;
    longint at = 0;
    fwd(2'd3, 32'hA000, 0, 1, 0, 0, 2'd2, 0, 0, "R7 reset count");
    @(negedge clk);
    core_req_valid = 1'b1; core_req_cmd = 2'd3; core_req_addr = 32'hB000;
    core_req_uncached = 1'b0;
    for (int i = 1; i <= PERIOD; i++) begin
      @(negedge clk);
      if (fail_count != CW'(i)) bad++;
      if (livelock_warn) begin
        pulses++;
        at = fail_count;
      end
    end
    core_req_valid = 1'b0;
    chk(bad == 0, "R6 count tracks", bad, 0);
    chk(pulses == 1, "R6 one pulse", pulses, 1);
    chk(at == PERIOD, "R6 pulse at period", at, PERIOD);
    @(negedge clk);
    chk(!livelock_warn && fail_count == PERIOD, "R6 pulse ends", livelock_warn, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_granule();
    t_plain();
    t_mem_fail();
    t_uncached();
    t_backpressure();
    t_livelock();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule